// File: doc/BRIEF.md
# Per-Lane Transmit Enable Guard with Fault Lockout

This block decides, for each of a set of transmit lanes (four by default), whether the lane's output driver may be on. It combines four things per lane: a raw fault indication from the driver's fault detector, a raw loss-of-input-signal indication, a software disable bit and a software squelch-override bit. The result is one registered enable per lane. It also keeps a latched fault flag per lane that software clears by reading it.

A fault does more than gate the output while it lasts. It puts the lane into a lockout state that survives the fault going away. Software releases the lockout by pulsing that lane's disable bit high and then low again, or by applying a module reset. Either path succeeds only if the fault has gone by then. Loss of input signal mutes the lane only while it is present, and software can override that muting per lane. All control inputs are held by the surrounding register logic. Their reset value of zero means the lane is not disabled and squelch is active.

Top module: `lane_txen_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every bit of `tx_en` and `fault_flag` is 0 after that edge, and every lane's lockout is cleared.
- R2: If `fault_in[i]` is 1 at an edge, lane i enters lockout and `tx_en[i]` is 0 after that edge.
- R3: A locked lane stays locked, with `tx_en[i]` at 0, after its fault input returns to 0, for as long as no release event occurs.
- R4: A release event on lane i is a falling edge of `tx_dis[i]`: the bit was 1 at the previous edge and is 0 at this edge. If `fault_in[i]` is 0 at that edge, the lockout clears, and `tx_en[i]` may be 1 after that same edge.
- R5: A falling edge of `tx_dis[i]` at an edge where `fault_in[i]` is still 1 leaves the lane locked.
- R6: A module reset clears the lockout. If the fault is still present when reset is released, the lane locks again at the first edge after release, and `tx_en[i]` never goes to 1.
- R7: When `los_in[i]` is 1 and `sq_dis[i]` is 0, `tx_en[i]` is 0 after the edge. When `sq_dis[i]` is 1, `los_in[i]` has no effect on `tx_en[i]`.
- R8: When `tx_dis[i]` is 1, `tx_en[i]` is 0 after the edge. `tx_en[i]` is 1 after an edge exactly when, at that edge, the disable bit is 0, the lane is not locked (updated state) and the lane is not squelched.
- R9: `fault_flag[i]` becomes 1 after any edge with `fault_in[i]` at 1. It then stays 1 until an edge with `flag_rd` at 1, whether or not the fault clears.
- R10: At an edge with `flag_rd` at 1, every flag whose fault input is 0 clears. A flag whose fault input is still 1 stays 1. Lanes are independent.
- R11: All outputs are registered and reflect the inputs sampled at the previous rising edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low module reset |
| fault_in | input | N_LANES | Raw per-lane driver fault indication |
| los_in | input | N_LANES | Raw per-lane loss-of-input-signal indication |
| tx_dis | input | N_LANES | Software disable per lane, 1 = disabled |
| sq_dis | input | N_LANES | Squelch override per lane, 1 = loss of signal ignored |
| flag_rd | input | 1 | Read strobe for the fault flags, clears them |
| tx_en | output | N_LANES | Registered output enable per lane |
| fault_flag | output | N_LANES | Latched fault status per lane |

## Verification
The hardest case to reach is the failed release: a disable pulse whose falling edge lands while the fault is still present. Right after it comes a clean pulse that does release the lane. The stimulus holds one lane's fault high across a full disable pulse, checks that the lane stays dark, then drops the fault and pulses again. A second case resets the block while a fault is still present and checks that the enable never rises after reset is released. Flag clearing is driven in the same cycle as a new fault on a neighbouring lane, to show that lanes do not interact.

// File: rtl/lane_txen_pkg.sv
// Package: shared constants and types for the transmit enable guard.
// Assumes all lane vectors are indexed from 0 upward, lane 0 first.
package lane_txen_pkg;

    parameter int unsigned LANES_DEFAULT = 4;

    // Lockout state of one lane.
    typedef enum logic {
        LANE_RUN    = 1'b0,
        LANE_LOCKED = 1'b1
    } lane_lock_e;

endpackage

// File: rtl/lane_lock_cell.sv
// Module: lockout state of one lane.
// Enters lockout whenever the raw fault is seen. Leaves it only on a
// 1-to-0 transition of the disable bit with the fault absent. Assumes the
// fault and disable inputs are already synchronous to clk.
module lane_lock_cell
    import lane_txen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic dis,
    output logic locked,
    output logic lock_next,
    output logic dis_prev
);

    lane_lock_e state_q;
    lane_lock_e state_d;
    logic       dis_fall;

    // Detect the release event: disable seen high last edge, low now.
    assign dis_fall = dis_prev & ~dis;

    // Next lockout state: a fault always wins over a release.
    always_comb begin
        state_d = state_q;
        if (fault) begin
            state_d = LANE_LOCKED;
        end else if (state_q == LANE_LOCKED && dis_fall) begin
            state_d = LANE_RUN;
        end
    end

    // State and disable history registers, cleared by module reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= LANE_RUN;
            dis_prev <= 1'b0;
        end else begin
            state_q  <= state_d;
            dis_prev <= dis;
        end
    end

    assign locked    = (state_q == LANE_LOCKED);
    assign lock_next = (state_d == LANE_LOCKED);

endmodule

// File: rtl/lane_flag_cell.sv
// Module: sticky fault flag of one lane with clear-on-read.
// A fault present in the same cycle as the read keeps the flag set.
module lane_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic rd,
    output logic flag
);

    // Set on fault, hold otherwise, clear when read and no fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= fault | (flag & ~rd);
        end
    end

endmodule

// File: rtl/lane_out_gate.sv
// Module: registered output enable of one lane.
// Combines disable, updated lockout state and squelch. Assumes lock_next
// is the lockout state that takes effect at this same edge.
module lane_out_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic dis,
    input  logic lock_next,
    input  logic los,
    input  logic sq_dis,
    output logic en
);

    logic squelch;

    // Loss of signal mutes the lane unless the override is set.
    assign squelch = los & ~sq_dis;

    // Output register: on only when every condition allows it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else begin
            en <= ~dis & ~lock_next & ~squelch;
        end
    end

endmodule

// File: rtl/lane_txen_ctrl.sv
// Module: top of the per-lane transmit enable guard.
// Instantiates one lockout cell, one flag cell and one output gate per
// lane. Assumes every input is synchronous to clk and held by the caller.
module lane_txen_ctrl
    import lane_txen_pkg::*;
#(
    parameter int unsigned N_LANES = LANES_DEFAULT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LANES-1:0] fault_in,
    input  logic [N_LANES-1:0] los_in,
    input  logic [N_LANES-1:0] tx_dis,
    input  logic [N_LANES-1:0] sq_dis,
    input  logic               flag_rd,
    output logic [N_LANES-1:0] tx_en,
    output logic [N_LANES-1:0] fault_flag
);

    logic [N_LANES-1:0] lock_vec;
    logic [N_LANES-1:0] lock_nx_vec;
    logic [N_LANES-1:0] dprev_vec;

    // One independent slice of logic per lane.
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        lane_lock_cell u_lock (
            .clk       (clk),
            .rst_n     (rst_n),
            .fault     (fault_in[g]),
            .dis       (tx_dis[g]),
            .locked    (lock_vec[g]),
            .lock_next (lock_nx_vec[g]),
            .dis_prev  (dprev_vec[g])
        );

        lane_flag_cell u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .fault (fault_in[g]),
            .rd    (flag_rd),
            .flag  (fault_flag[g])
        );

        lane_out_gate u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .dis       (tx_dis[g]),
            .lock_next (lock_nx_vec[g]),
            .los       (los_in[g]),
            .sq_dis    (sq_dis[g]),
            .en        (tx_en[g])
        );
    end

endmodule

// File: rtl/lane_txen_chk.sv
// Checker: temporal properties of the transmit enable guard, bound to the top.
module lane_txen_chk #(
    parameter int unsigned N_LANES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LANES-1:0] fault_in,
    input logic [N_LANES-1:0] los_in,
    input logic [N_LANES-1:0] tx_dis,
    input logic [N_LANES-1:0] sq_dis,
    input logic               flag_rd,
    input logic [N_LANES-1:0] tx_en,
    input logic [N_LANES-1:0] fault_flag,
    input logic [N_LANES-1:0] lock_vec,
    input logic [N_LANES-1:0] dprev_vec
);

    // R1: reset empties the outputs after the edge.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (tx_en == '0 && fault_flag == '0 && lock_vec == '0));

    // R2: a fault at an edge leaves the lane dark after it.
    a_r2_fault_darkens: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((tx_en & $past(fault_in)) == '0));

    // R3: lockout persists unless a release event occurred.
    a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(lock_vec & ~(dprev_vec & ~tx_dis)) & ~lock_vec) == '0));

    // R7: an unmasked loss of signal darkens the lane.
    a_r7_squelch: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((tx_en & $past(los_in & ~sq_dis)) == '0));

    // R8: a disabled lane is dark.
    a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((tx_en & $past(tx_dis)) == '0));

    // R9: a fault sets the flag.
    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(fault_in) & ~fault_flag) == '0));

    // R9: without a read, flags never fall.
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_rd |=> (($past(fault_flag) & ~fault_flag) == '0));

endmodule

bind lane_txen_ctrl lane_txen_chk #(.N_LANES(N_LANES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_in   (fault_in),
    .los_in     (los_in),
    .tx_dis     (tx_dis),
    .sq_dis     (sq_dis),
    .flag_rd    (flag_rd),
    .tx_en      (tx_en),
    .fault_flag (fault_flag),
    .lock_vec   (lock_vec),
    .dprev_vec  (dprev_vec)
);

// File: tb/lane_txen_ctrl_tb_top.sv
// Bench: scoreboard for the transmit enable guard. The driver applies one
// vector per cycle on the falling edge and queues the expected outputs.
// The monitor compares them just after the next rising edge.
module lane_txen_ctrl_tb_top;

    localparam int N = 4;

    typedef struct {
        logic [N-1:0] en;
        logic [N-1:0] flg;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] fault_in = '0;
    logic [N-1:0] los_in = '0;
    logic [N-1:0] tx_dis = '0;
    logic [N-1:0] sq_dis = '0;
    logic         flag_rd = 1'b0;
    logic [N-1:0] tx_en;
    logic [N-1:0] fault_flag;

    exp_t         exp_q[$];
    int           n_chk = 0;
    int           n_bad = 0;
    int           cyc = 0;

    // Reference state built from the requirements.
    logic [N-1:0] m_lock = '0;
    logic [N-1:0] m_dprev = '0;
    logic [N-1:0] m_flag = '0;

    always #2.5 clk = ~clk;

    lane_txen_ctrl #(.N_LANES(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_in   (fault_in),
        .los_in     (los_in),
        .tx_dis     (tx_dis),
        .sq_dis     (sq_dis),
        .flag_rd    (flag_rd),
        .tx_en      (tx_en),
        .fault_flag (fault_flag)
    );

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Driver: apply one vector and queue what the ports must show next.
    task automatic step(input logic rst, input logic [N-1:0] f,
                        input logic [N-1:0] l, input logic [N-1:0] d,
                        input logic [N-1:0] s, input logic rd,
                        input string tag);
        exp_t e;
        logic [N-1:0] lock_n;
        @(negedge clk);
        rst_n = rst; fault_in = f; los_in = l; tx_dis = d;
        sq_dis = s; flag_rd = rd;
        if (!rst) begin
            m_lock = '0; m_dprev = '0; m_flag = '0;
            e.en = '0;
        end else begin
            lock_n  = f | (m_lock & ~(m_dprev & ~d));
            e.en    = ~d & ~lock_n & ~(l & ~s);
            m_flag  = f | (m_flag & ~{N{rd}});
            m_lock  = lock_n;
            m_dprev = d;
        end
        e.flg = m_flag;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare once per rising edge that has a queued item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (tx_en !== e.en || fault_flag !== e.flg) begin
                    n_bad++;
                    $display("FAIL %s: tx_en=%b flag=%b expected tx_en=%b flag=%b",
                             e.tag, tx_en, fault_flag, e.en, e.flg);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a miscompare.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected <= 5000", cyc);
            finish_run();
        end
    end

    initial begin
        // R1: reset with a fault and a disable present.
        step(0, 4'b0001, 4'b0000, 4'b0010, 4'b0000, 0, "R1");
        step(0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, "R1");
        // R11 and R8: all lanes clear, all on one cycle later.
        step(1, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, "R11");
        // R2, R7, R8: fault on 0, LOS on 1 and 2 (2 overridden), disable on 3.
        step(1, 4'b0001, 4'b0110, 4'b1000, 4'b0100, 0, "R2");
        // R3 and R9: fault gone, lane 0 stays dark, flag held.
        step(1, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, "R3");
        step(1, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, "R9");
        // R7: override on lane 1 makes LOS ignored there.
        step(1, 4'b0000, 4'b0010, 4'b0000, 4'b0010, 0, "R7");
        // R10: read clears flag of lane 0.
        step(1, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1, "R10");
        step(1, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, "R3");
        // R5: fault returns, disable pulse falls while fault is present.
        step(1, 4'b0001, 4'b0000, 4'b0001, 4'b0000, 0, "R5");
        step(1, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 0, "R5");
        step(1, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, "R5");
        // R4: clean pulse releases lane 0 on the falling edge.
        step(1, 4'b0000, 4'b0000, 4'b0001, 4'b0000, 0, "R8");
        step(1, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, "R4");
        // R10: read with fault still present on lane 2, new fault lane 1.
        step(1, 4'b0100, 4'b0000, 4'b0000, 4'b0000, 0, "R9");
        step(1, 4'b0110, 4'b0000, 4'b0000, 4'b0000, 1, "R10");
        step(1, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1, "R10");
        // R6: reset while lane 3 faults, fault held after release.
        step(1, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 0, "R2");
        step(0, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 0, "R6");
        step(1, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 0, "R6");
        step(1, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, "R6");
        // R6: reset with the fault gone restores the lane.
        step(0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, "R1");
        step(1, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, "R6");
        // R4: rising disable alone does not release a locked lane.
        step(1, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 0, "R2");
        step(1, 4'b0000, 4'b0000, 4'b0010, 4'b0000, 0, "R3");
        step(1, 4'b0000, 4'b0000, 4'b0010, 4'b0000, 0, "R3");
        step(1, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, "R4");
        step(1, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 0, "R7");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule